// File: doc/BRIEF.md
# Programmable Timer Tick Prescaler

This block generates a one-cycle enable pulse that acts as the common time base for a group of timers and a watchdog. A 4-bit down counter runs on the system clock. When it hits zero it asserts the tick and reloads from a software-written ratio register. The tick rate is therefore the system clock divided by any value from 1 to 16.

The ratio register is written through a simple enable/data port. A new value never shortens the count that is already running; it is used from the next reload onward. A mode strap is sampled only while reset is active, and it picks the default ratio. In fast mode the default gives a tick on every cycle. In compatibility mode the default gives a tick every sixth cycle. The timers and watchdog that consume the tick sit outside this block.

Top module: `tick_prescaler`

## Requirements
- R1: While the ratio register holds value N (4 bits, 0 to 15), tick_o is high once every N+1 clock cycles.
- R2: For N greater than 0, each tick lasts exactly one cycle. For N equal to 0, tick_o stays high on every cycle.
- R3: Reset with compat_mode_i low loads ratio 4'b0000 into both the register and the counter, so tick_o is high from reset release and on every cycle after it.
- R4: Reset with compat_mode_i high loads ratio 4'b0101 into both the register and the counter. The first tick comes 5 cycles after reset release, and a tick follows every 6 cycles after that.
- R5: A write at a clock edge takes effect at the first reload after that edge. A write at the reload edge itself does not change the reload value used at that edge. The period in progress runs to its end with the old value.
- R6: compat_mode_i has no effect while rst_ni is high.
- R7: wr_ratio_i is ignored while wr_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| compat_mode_i | input | 1 | Mode strap; high selects the compatibility default ratio during reset |
| wr_en_i | input | 1 | Ratio register write enable |
| wr_ratio_i | input | 4 | New ratio value (division = value + 1) |
| tick_o | output | 1 | Shared timer tick enable |

## Verification
On every cycle, the bound checker confirms four things:
- the counter steps down by one when it is nonzero;
- the counter reloads from the ratio register when it is zero;
- the ratio register changes only on a write;
- a tick never lasts past one cycle when the ratio is nonzero.

Only the bench scenarios can show the end-to-end tick spacing. These scenarios cover all sixteen ratios, both reset defaults, the first-tick delay after reset, a mode strap that is ignored at run time, and a period that is not cut short when the ratio is rewritten partway through or at the reload edge.

// File: rtl/tick_prescaler_pkg.sv
package tick_prescaler_pkg;
  localparam int unsigned CNT_W          = 4;
  localparam int unsigned FAST_RATIO     = 0;
  localparam int unsigned COMPAT_RATIO   = 5;
endpackage

// File: rtl/tps_ratio_reg.sv
module tps_ratio_reg #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rst_val_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] ratio_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ratio_o <= rst_val_i;
    else if (wr_en_i) ratio_o <= wr_data_i;
  end
endmodule

// File: rtl/tps_down_counter.sv
module tps_down_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rst_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] One = {{(CNT_W-1){1'b0}}, 1'b1};

  assign zero_o = (cnt_o == '0);

  // reload uses the ratio held before this edge; a same-edge write lands next period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= rst_val_i;
    else if (zero_o) cnt_o <= reload_i;
    else             cnt_o <= cnt_o - One;
  end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_prescaler_pkg::*;
#(
  parameter int unsigned RATIO_W     = CNT_W,
  parameter int unsigned FAST_DEF    = FAST_RATIO,
  parameter int unsigned COMPAT_DEF  = COMPAT_RATIO
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               compat_mode_i,
  input  logic               wr_en_i,
  input  logic [RATIO_W-1:0] wr_ratio_i,
  output logic               tick_o
);
  localparam logic [RATIO_W-1:0] FastVal   = RATIO_W'(FAST_DEF);
  localparam logic [RATIO_W-1:0] CompatVal = RATIO_W'(COMPAT_DEF);

  logic [RATIO_W-1:0] def_ratio;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               zero;

  // strap only matters while reset holds the registers
  assign def_ratio = compat_mode_i ? CompatVal : FastVal;

  tps_ratio_reg #(.CNT_W(RATIO_W)) u_ratio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (def_ratio),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_ratio_i),
    .ratio_o   (ratio_q)
  );

  tps_down_counter #(.CNT_W(RATIO_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i (def_ratio),
    .reload_i  (ratio_q),
    .cnt_o     (cnt_q),
    .zero_o    (zero)
  );

  assign tick_o = zero;
endmodule

// File: rtl/tick_prescaler_chk.sv
module tick_prescaler_chk #(
  parameter int unsigned RATIO_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [RATIO_W-1:0] wr_ratio_i,
  input logic               tick_o,
  input logic [RATIO_W-1:0] cnt_q,
  input logic [RATIO_W-1:0] ratio_q
);
  p_count_down_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_reload_old_ratio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |=> (cnt_q == $past(ratio_q)));

  p_write_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ratio_q == $past(wr_ratio_i)));

  p_ratio_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ratio_q));

  p_single_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && ratio_q != '0) |=> !tick_o);
endmodule

bind tick_prescaler tick_prescaler_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_ratio_i (wr_ratio_i),
  .tick_o     (tick_o),
  .cnt_q      (cnt_q),
  .ratio_q    (ratio_q)
);

// File: tb/tick_prescaler_test.sv
module tick_prescaler_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       compat_mode_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_ratio_i = 4'd0;
  logic       tick_o;

  int n_chk = 0;
  int n_bad = 0;

  tick_prescaler uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .compat_mode_i(compat_mode_i),
    .wr_en_i(wr_en_i), .wr_ratio_i(wr_ratio_i), .tick_o(tick_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycles from the current sample to the next sample with tick high
  task automatic to_tick(output int n);
    n = 0;
    do begin step(); n++; end while (!tick_o && n < 64);
  endtask

  task automatic do_reset(input logic compat);
    rst_ni = 1'b0; compat_mode_i = compat; wr_en_i = 1'b0;
    step(); step();
    rst_ni = 1'b1;
  endtask

  // write at a tick sample: the edge both reloads (old) and writes (new)
  task automatic write_at_tick(input int r, input int old_r);
    int m;
    int n;
    wr_en_i = 1'b1; wr_ratio_i = 4'(r);
    step();
    wr_en_i = 1'b0;
    n = 1;
    if (!tick_o) begin to_tick(m); n += m; end
    check("R5 same-edge write keeps old period", n, old_r + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int n;
    int cur;
    // fast-mode reset
    do_reset(1'b0);
    check("R3 tick at reset release", int'(tick_o), 1);
    for (int i = 0; i < 20; i++) begin
      step();
      check("R3 tick every cycle", int'(tick_o), 1);
    end

    // compat-mode reset
    do_reset(1'b1);
    check("R4 no tick at reset release", int'(tick_o), 0);
    to_tick(n);
    check("R4 first tick delay", n, 5);
    for (int i = 0; i < 3; i++) begin
      to_tick(n);
      check("R4 period six", n, 6);
    end

    // strap changed at run time
    compat_mode_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      to_tick(n);
      check("R6 strap ignored after reset", n, 6);
    end

    // sweep all ratios
    cur = 5;
    for (int r = 0; r < 16; r++) begin
      write_at_tick(r, cur);
      cur = r;
      for (int k = 0; k < 3; k++) begin
        to_tick(n);
        check("R1 period ratio+1", n, r + 1);
      end
      if (r > 0) begin
        step();
        check("R2 one-cycle tick", int'(tick_o), 0);
        to_tick(n);
        check("R2 remainder of period", n, r);
      end else begin
        for (int k = 0; k < 4; k++) begin
          step();
          check("R2 ratio 0 constant tick", int'(tick_o), 1);
        end
      end
    end

    // mid-period write: ratio 15 running, change to 2 after 3 cycles
    step(); step(); step();
    wr_en_i = 1'b1; wr_ratio_i = 4'd2;
    step();
    wr_en_i = 1'b0;
    to_tick(n);
    check("R5 period not cut short", n, 12);
    to_tick(n);
    check("R5 new ratio after reload", n, 3);

    // data toggling without enable
    for (int i = 0; i < 4; i++) begin
      wr_ratio_i = 4'(7 + i);
      to_tick(n);
      check("R7 data ignored without enable", n, 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule